// File: doc/BRIEF.md
# Counter Overflow Interrupt Enable Register

This block holds the per-counter enables that decide which performance-counter overflows may raise an interrupt. It has one enable for the cycle counter and one for each implemented event counter. Software changes it only through set-only writes, so a 1 in the write data turns an enable on and a 0 leaves that enable as it was. Clearing is done by a separate companion register, which is outside this block. The block also combines the enables with the overflow flags that arrive from outside and drives a single registered interrupt line.

Each access arrives as a coprocessor-style register transfer: a strobe, a read/write flag, the five encoding fields, write data and the current exception level. The block checks the encoding. It then runs the access through a fixed-priority permission check driven by trap-control inputs from the higher exception levels. In the same cycle it returns one of four outcome codes: permitted, undefined, trap to EL2, or trap to EL3. A trap also reports its syndrome class. Only a permitted access reads or writes the enables.

Top module: `pmu_ovf_irq_enable`

## Requirements
- R1: The register is selected only when coproc=4'b1111, opc1=3'b000, CRn=4'b1001, CRm=4'b1110 and opc2=3'b001, for reads and for writes. An access with any other encoding changes no enable, returns rdata 0 and reports outcome 0.
- R2: A permitted write sets every implemented enable whose write-data bit is 1. Enables whose write-data bit is 0 keep their value.
- R3: A permitted read returns the 32-bit enable state in rdata during the access cycle. Bit 31 belongs to the cycle counter and bit k (0 to 30) to event counter k.
- R4: Parameter EVT_CNT (0 to 31) sets how many event counters exist. Only bit 31 and bits EVT_CNT-1 down to 0 can be set. All other bits read 0 and ignore writes.
- R5: An access from EL0 (cur_el=2'd0) reports outcome 1 (undefined).
- R6: An access from EL3 (cur_el=2'd3) is always permitted (outcome 0).
- R7: From EL1, the first matching rule applies, in this order. (a) EL3 present and 64-bit, its counter-trap bit set, and the secure-debug priority condition set: undefined (1). (b) EL2 enabled and its CRn-9 trap bit set, using the 64-bit or 32-bit form to match EL2's state: trap to EL2 (2). (c) EL2 enabled and its counter-trap bit set, using the form that matches EL2's state: trap to EL2 (2). (d) EL3 present and 64-bit with its counter-trap bit set: undefined (1) if the secure-debug condition holds, otherwise trap to EL3 (3). If no rule matches, the access is permitted (0).
- R8: From EL2 (cur_el=2'd2), only rules (a) and (d) of R7 apply, in that order. If neither matches, the access is permitted.
- R9: Outcomes 2 and 3 report syndrome 6'h03. Every other outcome reports syndrome 0.
- R10: An access that is not permitted changes no enable and returns rdata 0.
- R11: The outcome, syndrome and rdata belong to the same cycle as the access strobe. An enable write takes effect at the clock edge that ends the access.
- R12: irq is the OR over all bits of (ovf_flags AND enable), registered once. It reflects flags and enables at the edge before the one that updates it.
- R13: A synchronous active-low reset clears all enables and irq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | Access strobe |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_coproc | input | 4 | Coprocessor number field |
| acc_opc1 | input | 3 | First opcode field |
| acc_crn | input | 4 | Primary register field |
| acc_crm | input | 4 | Secondary register field |
| acc_opc2 | input | 3 | Second opcode field |
| acc_wdata | input | 32 | Write data |
| cur_el | input | 2 | Exception level of the access |
| el2_enabled | input | 1 | EL2 enabled in the current state |
| el2_is_a64 | input | 1 | EL2 uses the 64-bit state |
| el3_present | input | 1 | EL3 implemented |
| el3_is_a64 | input | 1 | EL3 uses the 64-bit state |
| el3_cnt_trap | input | 1 | EL3 counter-access trap bit |
| el2_cnt_trap_a64 | input | 1 | EL2 counter-access trap bit, 64-bit form |
| el2_cnt_trap_a32 | input | 1 | EL2 counter-access trap bit, 32-bit form |
| el2_crn9_trap_a64 | input | 1 | EL2 CRn-9 trap bit, 64-bit form |
| el2_crn9_trap_a32 | input | 1 | EL2 CRn-9 trap bit, 32-bit form |
| sec_dbg_undef_prio | input | 1 | Secure-debug undefined takes priority |
| sec_dbg_undef | input | 1 | Secure-debug undefined condition |
| ovf_flags | input | 32 | Overflow flags, same bit layout as the enables |
| rdata | output | 32 | Read data |
| outcome | output | 2 | 0 permitted, 1 undefined, 2 trap EL2, 3 trap EL3 |
| syndrome | output | 6 | Syndrome class of a trap |
| irq | output | 1 | Registered overflow interrupt request |

## Verification
The outcome, syndrome and read data are combinational, so the bench checks them in the middle of the access cycle, one half-period after driving inputs and before the clock edge. A write changes the enables at the next edge, and a read issued one cycle later shows the change. irq trails by one more register: the reference model computes it from the flags and the enables it held just before the edge, and the bench compares it shortly after that edge. The bench checks all three on every clock, so a result that shows up a cycle early or a cycle late is reported.

// File: rtl/pmu_ovf_pkg.sv
package pmu_ovf_pkg;

   localparam int REG_W = 32;
   localparam int CYC_BIT = REG_W - 1;
   localparam int EC_W = 6;
   localparam logic [EC_W-1:0] TRAP_EC = 6'h03;

   localparam logic [3:0] SEL_COPROC = 4'b1111;
   localparam logic [2:0] SEL_OPC1 = 3'b000;
   localparam logic [3:0] SEL_CRN = 4'b1001;
   localparam logic [3:0] SEL_CRM = 4'b1110;
   localparam logic [2:0] SEL_OPC2 = 3'b001;

   typedef enum logic [1:0] {
      ACC_OK       = 2'd0,
      ACC_UNDEF    = 2'd1,
      ACC_TRAP_EL2 = 2'd2,
      ACC_TRAP_EL3 = 2'd3
   } acc_res_e;

   typedef enum logic [1:0] {
      LVL0 = 2'd0,
      LVL1 = 2'd1,
      LVL2 = 2'd2,
      LVL3 = 2'd3
   } lvl_e;

   function automatic logic [REG_W-1:0] impl_mask(input int evt_cnt);
      logic [REG_W-1:0] m;
      m = '0;
      for (int i = 0; i < REG_W - 1; i++) begin
         if (i < evt_cnt) m[i] = 1'b1;
      end
      m[CYC_BIT] = 1'b1;
      return m;
   endfunction

endpackage

// File: rtl/pmu_acc_decode.sv
module pmu_acc_decode
   import pmu_ovf_pkg::*;
(
   input  logic [3:0] coproc,
   input  logic [2:0] opc1,
   input  logic [3:0] crn,
   input  logic [3:0] crm,
   input  logic [2:0] opc2,
   output logic       hit
);

   logic [4:0] fld_match;

   always_comb begin
      fld_match[0] = (coproc == SEL_COPROC);
      fld_match[1] = (opc1   == SEL_OPC1);
      fld_match[2] = (crn    == SEL_CRN);
      fld_match[3] = (crm    == SEL_CRM);
      fld_match[4] = (opc2   == SEL_OPC2);
      hit = &fld_match;
   end

endmodule

// File: rtl/pmu_acc_permit.sv
module pmu_acc_permit
   import pmu_ovf_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req,
   input  logic [1:0]      lvl,
   input  logic            el2_enabled,
   input  logic            el2_is_a64,
   input  logic            el3_present,
   input  logic            el3_is_a64,
   input  logic            el3_cnt_trap,
   input  logic            el2_cnt_trap_a64,
   input  logic            el2_cnt_trap_a32,
   input  logic            el2_crn9_trap_a64,
   input  logic            el2_crn9_trap_a32,
   input  logic            sec_dbg_undef_prio,
   input  logic            sec_dbg_undef,
   output acc_res_e        res,
   output logic [EC_W-1:0] ec
);

   logic el3_gate;
   logic el2_crn9;
   logic el2_cnt;

   always_comb begin
      el3_gate = el3_present && el3_is_a64 && el3_cnt_trap;
      el2_crn9 = el2_enabled && (el2_is_a64 ? el2_crn9_trap_a64 : el2_crn9_trap_a32);
      el2_cnt  = el2_enabled && (el2_is_a64 ? el2_cnt_trap_a64 : el2_cnt_trap_a32);
   end

   always_comb begin
      res = ACC_OK;
      if (req) begin
         unique case (lvl_e'(lvl))
            LVL0: res = ACC_UNDEF;
            LVL1: begin
               if (el3_gate && sec_dbg_undef_prio) res = ACC_UNDEF;
               else if (el2_crn9)                  res = ACC_TRAP_EL2;
               else if (el2_cnt)                   res = ACC_TRAP_EL2;
               else if (el3_gate)                  res = sec_dbg_undef ? ACC_UNDEF : ACC_TRAP_EL3;
               else                                res = ACC_OK;
            end
            LVL2: begin
               if (el3_gate && sec_dbg_undef_prio) res = ACC_UNDEF;
               else if (el3_gate)                  res = sec_dbg_undef ? ACC_UNDEF : ACC_TRAP_EL3;
               else                                res = ACC_OK;
            end
            LVL3: res = ACC_OK;
            default: res = ACC_UNDEF;
         endcase
      end
   end

   always_comb begin
      ec = (res == ACC_TRAP_EL2 || res == ACC_TRAP_EL3) ? TRAP_EC : '0;
   end

   assert_el0_undef_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (req && lvl == 2'd0) |-> res == ACC_UNDEF);

   assert_el3_open_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (req && lvl == 2'd3) |-> res == ACC_OK);

   assert_el2_never_self_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (req && lvl == 2'd2) |-> res != ACC_TRAP_EL2);

   assert_el1_crn9_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (req && lvl == 2'd1 && el2_enabled && el2_is_a64 && el2_crn9_trap_a64
       && !(el3_present && el3_is_a64 && el3_cnt_trap && sec_dbg_undef_prio))
      |-> res == ACC_TRAP_EL2);

   assert_trap_class_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (res == ACC_TRAP_EL2 || res == ACC_TRAP_EL3) |-> ec == 6'h03);

   assert_no_class_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (res == ACC_OK || res == ACC_UNDEF) |-> ec == '0);

endmodule

// File: rtl/pmu_ovf_enable_bank.sv
module pmu_ovf_enable_bank
   import pmu_ovf_pkg::*;
#(
   parameter int EVT_CNT = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             set_en,
   input  logic [REG_W-1:0] set_bits,
   output logic [REG_W-1:0] en
);

   localparam logic [REG_W-1:0] IMPL = impl_mask(EVT_CNT);

   logic [REG_W-1:0] set_gated;

   always_comb set_gated = set_en ? (set_bits & IMPL) : '0;

   for (genvar i = 0; i < REG_W; i++) begin : g_bit
      if (IMPL[i]) begin : g_impl
         always_ff @(posedge clk) begin
            if (!rst_n)           en[i] <= 1'b0;
            else if (set_gated[i]) en[i] <= 1'b1;
         end
      end else begin : g_rsvd
         always_ff @(posedge clk) en[i] <= 1'b0;
      end
   end

   assert_set_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((en & $past(en)) == $past(en)));

   assert_rsvd_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((en & ~IMPL) == '0));

   assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !set_en |=> $stable(en));

endmodule

// File: rtl/pmu_ovf_irq_merge.sv
module pmu_ovf_irq_merge
   import pmu_ovf_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [REG_W-1:0] flags,
   input  logic [REG_W-1:0] en,
   output logic             irq
);

   logic any_pend;

   always_comb any_pend = |(flags & en);

   always_ff @(posedge clk) begin
      if (!rst_n) irq <= 1'b0;
      else        irq <= any_pend;
   end

   assert_irq_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (flags == '0) |=> !irq);

   assert_irq_masked_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (en == '0) |=> !irq);

endmodule

// File: rtl/pmu_ovf_irq_enable.sv
module pmu_ovf_irq_enable
   import pmu_ovf_pkg::*;
#(
   parameter int EVT_CNT = 6
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        acc_valid,
   input  logic        acc_write,
   input  logic [3:0]  acc_coproc,
   input  logic [2:0]  acc_opc1,
   input  logic [3:0]  acc_crn,
   input  logic [3:0]  acc_crm,
   input  logic [2:0]  acc_opc2,
   input  logic [31:0] acc_wdata,
   input  logic [1:0]  cur_el,
   input  logic        el2_enabled,
   input  logic        el2_is_a64,
   input  logic        el3_present,
   input  logic        el3_is_a64,
   input  logic        el3_cnt_trap,
   input  logic        el2_cnt_trap_a64,
   input  logic        el2_cnt_trap_a32,
   input  logic        el2_crn9_trap_a64,
   input  logic        el2_crn9_trap_a32,
   input  logic        sec_dbg_undef_prio,
   input  logic        sec_dbg_undef,
   input  logic [31:0] ovf_flags,
   output logic [31:0] rdata,
   output logic [1:0]  outcome,
   output logic [5:0]  syndrome,
   output logic        irq
);

   if (EVT_CNT < 0 || EVT_CNT > REG_W - 1) begin : g_bad_cnt
      $error("EVT_CNT must lie between 0 and 31");
   end

   logic             sel_hit;
   logic             req;
   acc_res_e         res;
   logic [EC_W-1:0]  ec;
   logic             granted;
   logic [REG_W-1:0] en;

   pmu_acc_decode u_dec (
      .coproc (acc_coproc),
      .opc1   (acc_opc1),
      .crn    (acc_crn),
      .crm    (acc_crm),
      .opc2   (acc_opc2),
      .hit    (sel_hit)
   );

   always_comb req = acc_valid && sel_hit;

   pmu_acc_permit u_perm (
      .clk                (clk),
      .rst_n              (rst_n),
      .req                (req),
      .lvl                (cur_el),
      .el2_enabled        (el2_enabled),
      .el2_is_a64         (el2_is_a64),
      .el3_present        (el3_present),
      .el3_is_a64         (el3_is_a64),
      .el3_cnt_trap       (el3_cnt_trap),
      .el2_cnt_trap_a64   (el2_cnt_trap_a64),
      .el2_cnt_trap_a32   (el2_cnt_trap_a32),
      .el2_crn9_trap_a64  (el2_crn9_trap_a64),
      .el2_crn9_trap_a32  (el2_crn9_trap_a32),
      .sec_dbg_undef_prio (sec_dbg_undef_prio),
      .sec_dbg_undef      (sec_dbg_undef),
      .res                (res),
      .ec                 (ec)
   );

   always_comb granted = req && (res == ACC_OK);

   pmu_ovf_enable_bank #(.EVT_CNT(EVT_CNT)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_en   (granted && acc_write),
      .set_bits (acc_wdata),
      .en       (en)
   );

   pmu_ovf_irq_merge u_irq (
      .clk   (clk),
      .rst_n (rst_n),
      .flags (ovf_flags),
      .en    (en),
      .irq   (irq)
   );

   always_comb begin
      rdata    = (granted && !acc_write) ? en : '0;
      outcome  = res;
      syndrome = ec;
   end

   assert_denied_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (req && res != ACC_OK) |=> $stable(en));

   assert_denied_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (req && res != ACC_OK) |-> rdata == '0);

   assert_miss_ignored_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !sel_hit) |=> $stable(en));

   assert_miss_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !sel_hit) |-> (outcome == 2'd0 && rdata == '0));

endmodule

// File: tb/pmu_ovf_irq_enable_test.sv
`timescale 1ns/1ps
module pmu_ovf_irq_enable_test;

   localparam int EVT = 6;
   localparam logic [31:0] MASK = 32'h8000_003F;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic acc_valid = 1'b0, acc_write = 1'b0;
   logic [3:0] acc_coproc = '0, acc_crn = '0, acc_crm = '0;
   logic [2:0] acc_opc1 = '0, acc_opc2 = '0;
   logic [31:0] acc_wdata = '0;
   logic [1:0] cur_el = '0;
   logic el2_enabled = 0, el2_is_a64 = 0, el3_present = 0, el3_is_a64 = 0;
   logic el3_cnt_trap = 0, el2_cnt_trap_a64 = 0, el2_cnt_trap_a32 = 0;
   logic el2_crn9_trap_a64 = 0, el2_crn9_trap_a32 = 0;
   logic sec_dbg_undef_prio = 0, sec_dbg_undef = 0;
   logic [31:0] ovf_flags = '0;
   logic [31:0] rdata;
   logic [1:0] outcome;
   logic [5:0] syndrome;
   logic irq;

   int n_chk = 0;
   int n_fail = 0;
   logic [31:0] en_m = '0;
   logic irq_m = 1'b0;

   always #2 clk = ~clk;

   pmu_ovf_irq_enable #(.EVT_CNT(EVT)) uut (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
      .acc_coproc(acc_coproc), .acc_opc1(acc_opc1), .acc_crn(acc_crn),
      .acc_crm(acc_crm), .acc_opc2(acc_opc2), .acc_wdata(acc_wdata),
      .cur_el(cur_el), .el2_enabled(el2_enabled), .el2_is_a64(el2_is_a64),
      .el3_present(el3_present), .el3_is_a64(el3_is_a64),
      .el3_cnt_trap(el3_cnt_trap), .el2_cnt_trap_a64(el2_cnt_trap_a64),
      .el2_cnt_trap_a32(el2_cnt_trap_a32), .el2_crn9_trap_a64(el2_crn9_trap_a64),
      .el2_crn9_trap_a32(el2_crn9_trap_a32), .sec_dbg_undef_prio(sec_dbg_undef_prio),
      .sec_dbg_undef(sec_dbg_undef), .ovf_flags(ovf_flags), .rdata(rdata),
      .outcome(outcome), .syndrome(syndrome), .irq(irq)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic sel();
      return acc_valid && acc_coproc == 4'hF && acc_opc1 == 3'd0 && acc_crn == 4'h9
             && acc_crm == 4'hE && acc_opc2 == 3'd1;
   endfunction

   // Reference permission decision written from R5..R8
   function automatic logic [1:0] model_res();
      logic e3, t9, tp;
      if (!sel()) return 2'd0;
      e3 = el3_present && el3_is_a64 && el3_cnt_trap;
      t9 = el2_enabled && (el2_is_a64 ? el2_crn9_trap_a64 : el2_crn9_trap_a32);
      tp = el2_enabled && (el2_is_a64 ? el2_cnt_trap_a64 : el2_cnt_trap_a32);
      if (cur_el == 2'd0) return 2'd1;
      if (cur_el == 2'd3) return 2'd0;
      if (e3 && sec_dbg_undef_prio) return 2'd1;
      if (cur_el == 2'd1 && (t9 || tp)) return 2'd2;
      if (e3) return sec_dbg_undef ? 2'd1 : 2'd3;
      return 2'd0;
   endfunction

   // One clock: combinational results mid-cycle, irq just after the edge
   task automatic tick(input string tag);
      logic [1:0] r;
      @(negedge clk);
      r = model_res();
      chk({tag, " outcome R11"}, {30'd0, outcome}, {30'd0, r});
      chk({tag, " syndrome R9"}, {26'd0, syndrome}, (r >= 2'd2) ? 32'd3 : 32'd0);
      chk({tag, " rdata R3/R10"}, rdata,
          (sel() && r == 2'd0 && !acc_write) ? en_m : 32'd0);
      @(posedge clk);
      if (!rst_n) begin
         en_m = '0;
         irq_m = 1'b0;
      end else begin
         irq_m = |(ovf_flags & en_m);
         if (sel() && r == 2'd0 && acc_write) en_m = en_m | (acc_wdata & MASK);
      end
      #1;
      chk({tag, " irq R12"}, {31'd0, irq}, {31'd0, irq_m});
   endtask

   task automatic clr_ctl();
      el2_enabled = 0; el2_is_a64 = 0; el3_present = 0; el3_is_a64 = 0;
      el3_cnt_trap = 0; el2_cnt_trap_a64 = 0; el2_cnt_trap_a32 = 0;
      el2_crn9_trap_a64 = 0; el2_crn9_trap_a32 = 0;
      sec_dbg_undef_prio = 0; sec_dbg_undef = 0;
   endtask

   task automatic acc(input logic wr, input logic [31:0] d, input logic [1:0] el,
                      input string tag);
      acc_valid = 1; acc_write = wr; acc_wdata = d; cur_el = el;
      acc_coproc = 4'hF; acc_opc1 = 3'd0; acc_crn = 4'h9; acc_crm = 4'hE; acc_opc2 = 3'd1;
      tick(tag);
      acc_valid = 0; acc_write = 0; acc_wdata = '0;
   endtask

   task automatic idle(input string tag);
      acc_valid = 0;
      tick(tag);
   endtask

   task automatic rd3(input string tag, input logic [31:0] exp);
      acc(1'b0, '0, 2'd3, tag);
      chk({tag, " readback"}, en_m, exp);
   endtask

   initial begin
      #(4 * 200000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      rst_n = 0;
      repeat (3) @(posedge clk);
      #1;
      tick("R13 reset");
      rst_n = 1;
      #1;
      rd3("R13 reset value", 32'h0);

      // R2 R3 R6: set-only writes from EL3
      acc(1'b1, 32'h8000_0005, 2'd3, "R6 write");
      rd3("R2 first set", 32'h8000_0005);
      acc(1'b1, 32'h0000_0002, 2'd3, "R2 write zeros");
      rd3("R2 no clear", 32'h8000_0007);

      // R4: unimplemented bits
      acc(1'b1, 32'hFFFF_FFC0, 2'd3, "R4 rsvd write");
      rd3("R4 rsvd", 32'h8000_0007);

      // R1: wrong encodings
      acc_valid = 1; acc_write = 1; acc_wdata = 32'h0000_0038; cur_el = 2'd3;
      acc_coproc = 4'hF; acc_opc1 = 3'd0; acc_crn = 4'h9; acc_crm = 4'hD; acc_opc2 = 3'd1;
      tick("R1 crm miss");
      acc_crm = 4'hE; acc_opc2 = 3'd0;
      tick("R1 opc2 miss");
      acc_opc2 = 3'd1; acc_coproc = 4'hE;
      tick("R1 coproc miss");
      acc_valid = 0;
      rd3("R1 unchanged", 32'h8000_0007);

      // R5 R10: EL0
      acc(1'b1, 32'h0000_0038, 2'd0, "R5 el0 write");
      acc(1'b0, '0, 2'd0, "R5 el0 read");
      rd3("R10 el0 no change", 32'h8000_0007);

      // R7 priority chain from EL1
      el3_present = 1; el3_is_a64 = 1; el3_cnt_trap = 1; sec_dbg_undef_prio = 1;
      el2_enabled = 1; el2_is_a64 = 1; el2_crn9_trap_a64 = 1; el2_cnt_trap_a64 = 1;
      acc(1'b1, 32'h0000_0008, 2'd1, "R7 a undef");
      sec_dbg_undef_prio = 0;
      acc(1'b1, 32'h0000_0008, 2'd1, "R7 b crn9 trap");
      el2_crn9_trap_a64 = 0;
      acc(1'b0, '0, 2'd1, "R7 c cnt trap");
      el2_cnt_trap_a64 = 0;
      acc(1'b1, 32'h0000_0008, 2'd1, "R7 d el3 trap");
      sec_dbg_undef = 1;
      acc(1'b1, 32'h0000_0008, 2'd1, "R7 d undef");
      rd3("R10 trapped no change", 32'h8000_0007);
      el3_is_a64 = 0;
      el2_is_a64 = 0; el2_crn9_trap_a64 = 1; el2_cnt_trap_a64 = 1;
      acc(1'b1, 32'h0000_0008, 2'd1, "R7 a32 form ignores a64 bits");
      rd3("R7 permitted write", 32'h8000_000F);
      el2_crn9_trap_a32 = 1;
      acc(1'b0, '0, 2'd1, "R7 a32 crn9 trap");
      el2_enabled = 0;
      acc(1'b0, '0, 2'd1, "R7 el2 off read");
      clr_ctl();

      // R8 from EL2
      el2_enabled = 1; el2_is_a64 = 1; el2_crn9_trap_a64 = 1; el2_cnt_trap_a64 = 1;
      acc(1'b1, 32'h0000_0010, 2'd2, "R8 el2 traps ignored");
      rd3("R8 el2 write", 32'h8000_001F);
      el3_present = 1; el3_is_a64 = 1; el3_cnt_trap = 1;
      acc(1'b0, '0, 2'd2, "R8 el3 trap");
      sec_dbg_undef_prio = 1;
      acc(1'b0, '0, 2'd2, "R8 prio undef");
      clr_ctl();

      // R13 then R12
      rst_n = 0;
      tick("R13 reset again");
      rst_n = 1;
      rd3("R13 cleared", 32'h0);
      acc(1'b1, 32'h0000_0004, 2'd3, "R12 set bit2");
      ovf_flags = 32'h0000_0008;
      idle("R12 other flag");
      idle("R12 other flag hold");
      ovf_flags = 32'h0000_0004;
      idle("R12 flag edge");
      idle("R12 flag high");
      ovf_flags = 32'h8000_0000;
      idle("R12 cyc flag masked");
      acc(1'b1, 32'h8000_0000, 2'd3, "R12 set cyc");
      idle("R12 cyc flag enabled");
      ovf_flags = 32'h0;
      idle("R12 drop");
      idle("R12 low");

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule